// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit virtual page number into a physical page number by chasing two pointers through a page table held in memory. A translation request carries the page number and a mask of the access kinds wanted (read, write, execute). The walker reads one 32-bit word from the first-level table, located through a root register. If that word is non-zero, it is the base address of a second-level table. The walker then reads one entry from that table and checks it.

Each request ends in exactly one response. The response carries a 2-bit status and, on success, the physical page number. The memory side allows only one read in flight at a time. A read stays asserted with a steady address until memory answers.

The root register is loaded through a write strobe. A walk captures the root value at the moment its request is accepted. A root write in that same cycle therefore only affects later walks.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: The first read of a walk goes to root + VPN[19:10] × 4.
- R3: A first-level word of zero ends the walk with status 1 (no table), PPN 0, and no second read.
- R4: A non-zero first-level word is taken as a table base, and the second read goes to base + VPN[9:0] × 4.
- R5: A second-level entry with bit 0 (valid) clear gives status 2 (not present) and PPN 0.
- R6: The permission bits are read at bit 2 = read, bit 3 = write and bit 4 = execute. The request mask has bit 0 = read, bit 1 = write and bit 2 = execute. If any requested kind is not granted, the response is status 3 (protection fault) with PPN 0.
- R7: A valid entry that grants every requested kind gives status 0 and PPN = entry[31:12]. The dirty bit (bit 1) has no effect on the result.
- R8: Each accepted request gives exactly one `rsp_valid` pulse, one cycle long. `req_ready` is low from acceptance through the response cycle and high in the cycle after it.
- R9: While `mem_req` is high and no `mem_rsp_valid` has arrived, `mem_req` stays high and `mem_addr` stays unchanged.
- R10: `root_we` loads `root_wdata` into the root register. A request accepted in the same cycle as a root write walks from the previous root. Later requests use the new root.
- R11: The valid check takes precedence over the permission check. An invalid entry that grants nothing still reports status 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_we | input | 1 | Load strobe for the root register |
| root_wdata | input | 32 | New root table address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vpn | input | 20 | Virtual page number |
| req_acc | input | 3 | Requested access mask {exec, write, read} |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 no table, 2 not present, 3 protection |
| rsp_ppn | output | 20 | Physical page number (0 unless status 0) |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Read data |

## Verification
Two events can meet in one cycle: a root-register write and the acceptance of a new request. The bench raises `root_we` on the same edge at which a request is taken. It then checks that the first read address is derived from the old root and that the returned PPN comes from the old tree. A second request, issued immediately afterwards, must walk from the new root and return a different PPN. Separately, the memory answer can land in the very cycle a read is first issued, with zero latency. The same walks are also repeated with extra latency, to confirm the address is held and each walk still needs exactly one read per level.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int          IDX_W     = 10,
  parameter int          PPN_W     = 20,
  parameter logic [31:0] ROOT_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 root_we,
  input  logic [31:0]          root_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2*IDX_W-1:0]   req_vpn,
  input  logic [2:0]           req_acc,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_status,
  output logic [PPN_W-1:0]     rsp_ppn,
  output logic                 mem_req,
  output logic [31:0]          mem_addr,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data
);
  localparam int VPN_W = 2 * IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_DONE} st_t;

  st_t              st;
  logic [31:0]      root_q, base_q;
  logic [VPN_W-1:0] vpn_q;
  logic [2:0]       acc_q;
  logic [IDX_W-1:0] idx;
  logic [2:0]       granted;

  assign idx       = (st == S_L2) ? vpn_q[IDX_W-1:0] : vpn_q[VPN_W-1:IDX_W];
  assign mem_addr  = base_q + {{(30-IDX_W){1'b0}}, idx, 2'b00};
  assign mem_req   = (st == S_L1) || (st == S_L2);
  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign granted   = mem_rsp_data[4:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= ROOT_INIT;
    end else if (root_we) begin
      root_q <= root_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= '0;
      vpn_q      <= '0;
      acc_q      <= '0;
      rsp_status <= '0;
      rsp_ppn    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          base_q <= root_q;
          vpn_q  <= req_vpn;
          acc_q  <= req_acc;
          st     <= S_L1;
        end
        S_L1: if (mem_rsp_valid) begin
          if (mem_rsp_data == '0) begin
            rsp_status <= 2'd1;
            rsp_ppn    <= '0;
            st         <= S_DONE;
          end else begin
            base_q <= mem_rsp_data;
            st     <= S_L2;
          end
        end
        S_L2: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            rsp_status <= 2'd2;
            rsp_ppn    <= '0;
          end else if ((acc_q & ~granted) != 3'b000) begin
            rsp_status <= 2'd3;
            rsp_ppn    <= '0;
          end else begin
            rsp_status <= 2'd0;
            rsp_ppn    <= mem_rsp_data[31:32-PPN_W];
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr)); // R9

  AST_NULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_L1) && mem_rsp_valid && (mem_rsp_data == '0)
      |=> rsp_valid && (rsp_status == 2'd1) && !mem_req); // R3

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R8

  AST_FAULT_NO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_status != 2'd0) |-> rsp_ppn == '0); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready && !rsp_valid); // R8
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic [2:0]  req_acc = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [19:0] rsp_ppn;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem_img [logic [31:0]];
  int          lat = 0;
  int          wcnt = 0;
  logic [31:0] hold_addr = '0;
  int          unstable = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [4];

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_ppn(rsp_ppn),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (mem_req) begin
      if (wcnt == 0) hold_addr = mem_addr;
      else if (mem_addr != hold_addr) unstable++;
      if (wcnt >= lat) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 32'h0;
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
        rd_cnt++;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [19:0] vpn, input logic [2:0] acc, input bit wr_root,
                      input logic [31:0] new_root, output logic [1:0] st, output logic [19:0] ppn);
    int busy_bad = 0;
    bit got = 0;
    rd_cnt = 0;
    @(negedge clk);
    req_vpn = vpn; req_acc = acc; req_valid = 1'b1;
    root_we = wr_root; root_wdata = new_root;
    @(negedge clk);
    req_valid = 1'b0; root_we = 1'b0;
    for (int i = 0; i < 100 && !got; i++) begin
      if (req_ready) busy_bad++;
      if (rsp_valid) begin
        got = 1; st = rsp_status; ppn = rsp_ppn;
      end else begin
        @(negedge clk);
      end
    end
    chk(got, "R8 response seen", 32'(got), 32'd1);
    chk(busy_bad == 0, "R8 ready low while busy", 32'(busy_bad), 32'd0);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 single pulse then ready", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk(req_ready && !mem_req && !rsp_valid, "R1 reset state", {29'd0, req_ready, mem_req, rsp_valid}, 32'h4);
  endtask

  task automatic t_ok;
    logic [1:0] s; logic [19:0] p;
    walk({10'd3, 10'd5}, 3'b001, 0, 0, s, p);
    chk(rd_addr[0] == 32'h0001_000C, "R2 first read address", rd_addr[0], 32'h0001_000C);
    chk(rd_addr[1] == 32'h0002_0014, "R4 second read address", rd_addr[1], 32'h0002_0014);
    chk(s == 2'd0 && p == 20'hABCDE, "R7 read translation", {10'd0, s, p}, {12'd0, 20'hABCDE});
    walk({10'd3, 10'd5}, 3'b011, 0, 0, s, p);
    chk(s == 2'd0 && p == 20'hABCDE, "R7 read+write translation", {10'd0, s, p}, {12'd0, 20'hABCDE});
    walk({10'd1023, 10'd1023}, 3'b111, 0, 0, s, p);
    chk(rd_addr[0] == 32'h0001_0FFC && rd_addr[1] == 32'h0003_0FFC, "R4 top index addresses", rd_addr[1], 32'h0003_0FFC);
    chk(s == 2'd0 && p == 20'hFFFFF, "R7 all rights", {10'd0, s, p}, {12'd0, 20'hFFFFF});
  endtask

  task automatic t_dirty;
    logic [1:0] s; logic [19:0] p;
    walk({10'd3, 10'd6}, 3'b001, 0, 0, s, p);
    chk(s == 2'd0 && p == 20'h12345, "R7 dirty bit ignored", {10'd0, s, p}, {12'd0, 20'h12345});
  endtask

  task automatic t_null;
    logic [1:0] s; logic [19:0] p;
    walk({10'd4, 10'd0}, 3'b001, 0, 0, s, p);
    chk(s == 2'd1 && p == 0, "R3 no table status", {10'd0, s, p}, {12'd1, 20'd0});
    chk(rd_cnt == 1, "R3 single read", 32'(rd_cnt), 32'd1);
  endtask

  task automatic t_absent;
    logic [1:0] s; logic [19:0] p;
    walk({10'd3, 10'd7}, 3'b001, 0, 0, s, p);
    chk(s == 2'd2 && p == 0, "R5 not present", {10'd0, s, p}, {12'd2, 20'd0});
    walk({10'd3, 10'd8}, 3'b111, 0, 0, s, p);
    chk(s == 2'd2, "R11 valid before permission", {30'd0, s}, 32'd2);
  endtask

  task automatic t_perm;
    logic [1:0] s; logic [19:0] p;
    walk({10'd3, 10'd5}, 3'b100, 0, 0, s, p);
    chk(s == 2'd3 && p == 0, "R6 execute denied", {10'd0, s, p}, {12'd3, 20'd0});
    walk({10'd3, 10'd6}, 3'b010, 0, 0, s, p);
    chk(s == 2'd3, "R6 write denied", {30'd0, s}, 32'd3);
  endtask

  task automatic t_latency;
    logic [1:0] s; logic [19:0] p;
    lat = 3; unstable = 0;
    walk({10'd3, 10'd5}, 3'b001, 0, 0, s, p);
    chk(unstable == 0, "R9 address held", 32'(unstable), 32'd0);
    chk(rd_cnt == 2 && s == 2'd0 && p == 20'hABCDE, "R9 slow memory walk", 32'(rd_cnt), 32'd2);
    lat = 0;
  endtask

  task automatic t_root;
    logic [1:0] s; logic [19:0] p;
    walk({10'd3, 10'd5}, 3'b001, 1, 32'h0004_0000, s, p);
    chk(rd_addr[0] == 32'h0001_000C, "R10 same-cycle write uses old root", rd_addr[0], 32'h0001_000C);
    chk(p == 20'hABCDE, "R10 old tree result", {12'd0, p}, {12'd0, 20'hABCDE});
    walk({10'd3, 10'd5}, 3'b001, 0, 0, s, p);
    chk(rd_addr[0] == 32'h0004_000C, "R10 new root used", rd_addr[0], 32'h0004_000C);
    chk(s == 2'd0 && p == 20'h77777, "R10 new tree result", {10'd0, s, p}, {12'd0, 20'h77777});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem_img[32'h0001_000C] = 32'h0002_0000;
    mem_img[32'h0002_0014] = 32'hABCD_E00D;
    mem_img[32'h0002_0018] = 32'h1234_5007;
    mem_img[32'h0002_001C] = 32'h5555_501C;
    mem_img[32'h0002_0020] = 32'h0000_0000;
    mem_img[32'h0001_0FFC] = 32'h0003_0000;
    mem_img[32'h0003_0FFC] = 32'hFFFF_F01D;
    mem_img[32'h0004_000C] = 32'h0005_0000;
    mem_img[32'h0005_0014] = 32'h7777_7005;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    root_we = 1'b1; root_wdata = 32'h0001_0000;
    @(negedge clk);
    root_we = 1'b0;
    t_ok();
    t_dirty();
    t_null();
    t_absent();
    t_perm();
    t_latency();
    t_root();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule